// File: doc/BRIEF.md
# Programmable-Length Loop-Filter Counter

This block is the digital loop filter of a first-order all-digital phase-locked loop. It is a wrapping up/down counter whose length is chosen at run time by a 4-bit span code. The direction input is normally driven by a phase detector. While that detector sits above its balance point the counter climbs, and below it the counter falls. Each time the count wraps past its top it emits a one-clock carry pulse. Each time it wraps below zero it emits a one-clock borrow pulse. A downstream pulse add/delete stage uses these pulses to nudge the loop frequency.

Span code n from 1 to 15 gives a modulus K = 2^(n+2), which runs from 8 to 131072. A short counter gives a wide, fast-locking loop. A long counter gives a narrow, slow one. Span code 0 freezes the counter. The code may change while the loop runs. On a change, the count is folded into the new range by keeping its low bits, so it never sits outside the range and no spurious pulse appears.

Top module: `loop_filter_counter`

## Requirements
- R1: A synchronous active-low reset clears the count to zero and holds carry_pulse and borrow_pulse low, both during reset and in the first cycle after it.
- R2: With span_code = 0 the counter is frozen. No pulse is produced, and the count is kept for when a non-zero code returns.
- R3: With span_code = n (1..15) the modulus is K = 2^(n+2). Counting up from zero, the K-th enabled rising edge wraps the count to zero.
- R4: dir_dn = 0 counts up and dir_dn = 1 counts down. Both dir_dn and cnt_en are sampled at the rising clock edge. Counting down from zero wraps to K-1 on the first edge.
- R5: An upward wrap raises carry_pulse in the cycle after the wrapping edge, for exactly one clock.
- R6: A downward wrap raises borrow_pulse in the cycle after the wrapping edge, for exactly one clock.
- R7: carry_pulse and borrow_pulse are never high together.
- R8: With cnt_en = 0 the count is held and no pulse is produced.
- R9: When span_code changes, the count is reduced modulo the new K (its low bits are kept). No pulse is emitted by the change itself.
- R10: Over a run, the number of carries minus the number of borrows equals the net number of up steps divided by K.
- R11: At the largest code (15, K = 131072), a down step from zero borrows at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Count enable, sampled at the rising edge |
| dir_dn | input | 1 | Direction: 0 up, 1 down |
| span_code | input | 4 | Modulus select: 0 frozen, n gives K = 2^(n+2) |
| carry_pulse | output | 1 | One-clock pulse on an upward wrap |
| borrow_pulse | output | 1 | One-clock pulse on a downward wrap |

## Verification
The count itself is hidden, so it is hardest to check that a span change folds the count rather than clearing or keeping it. The bench sets a known count under a long modulus and then switches to a short one. It then counts the edges until the next carry or borrow. That edge count shows which residue was kept. The same method, with an edge count before the first pulse, shows that the count survives a frozen span code or a dropped enable.

// File: rtl/lfc_pkg.sv
// Package: shared types and constants for the loop-filter counter.
// Assumes: a span code of zero always means "frozen".
package lfc_pkg;

    // Direction encoding of the dir_dn input.
    typedef enum logic {
        DIR_UP = 1'b0,
        DIR_DN = 1'b1
    } dir_e;

    // Wrap events produced by one counting step.
    typedef struct packed {
        logic carry;
        logic borrow;
    } wrap_t;

    localparam wrap_t WRAP_NONE = '{carry: 1'b0, borrow: 1'b0};

endpackage

// File: rtl/lfc_modulus_decode.sv
// Module: turns the span code into a low-bit mask of the active modulus.
// Assumes: K = 2^(code + MIN_EXP - 1). Code 0 is inactive and yields an
// all-ones mask, so the held count is not folded while the counter is frozen.
module lfc_modulus_decode #(
    parameter int CODE_W  = 4,
    parameter int MIN_EXP = 3,
    parameter int CNT_W   = 17
) (
    input  logic [CODE_W-1:0] span_code,
    output logic [CNT_W-1:0]  mask,
    output logic              active
);
    localparam int EXP_OFS = MIN_EXP - 1;

    logic [CNT_W-1:0] mask_raw;

    // One comparator per count bit: the bit is live when it lies below the exponent.
    for (genvar b = 0; b < CNT_W; b++) begin : g_bit
        assign mask_raw[b] = ((int'(span_code) + EXP_OFS) > b);
    end

    // Select the live mask, or all ones when the counter is frozen.
    always_comb begin
        active = (span_code != '0);
        mask   = active ? mask_raw : '1;
    end
endmodule

// File: rtl/lfc_step_core.sv
// Module: combinational next-count and wrap detection for one clock step.
// Assumes: the mask is a contiguous run of low ones. The stored count is folded
// through the mask before use, which is how a modulus change shrinks it.
module lfc_step_core
    import lfc_pkg::*;
#(
    parameter int CNT_W = 17
) (
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] mask,
    input  logic             step_en,
    input  logic             dir_dn,
    output logic [CNT_W-1:0] cnt_d,
    output wrap_t            wrap_d
);
    logic [CNT_W-1:0] base;
    logic             at_top;
    logic             at_bot;

    // Fold the count into the current range and flag the two edges.
    always_comb begin
        base   = cnt_q & mask;
        at_top = (base == mask);
        at_bot = (base == '0);
    end

    // Compute the next count and the wrap event for this step.
    always_comb begin
        cnt_d  = base;
        wrap_d = WRAP_NONE;
        if (step_en) begin
            if (dir_e'(dir_dn) == DIR_DN) begin
                if (at_bot) begin
                    cnt_d         = mask;
                    wrap_d.borrow = 1'b1;
                end else begin
                    cnt_d = base - 1'b1;
                end
            end else begin
                if (at_top) begin
                    cnt_d        = '0;
                    wrap_d.carry = 1'b1;
                end else begin
                    cnt_d = base + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/lfc_state_reg.sv
// Module: count register and registered carry/borrow pulses.
// Assumes: synchronous active-low reset. Pulses last one cycle because
// wrap_d is recomputed on every edge.
module lfc_state_reg
    import lfc_pkg::*;
#(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_d,
    input  wrap_t            wrap_d,
    output logic [CNT_W-1:0] cnt_q,
    output wrap_t            wrap_q
);
    // Hold the count between steps.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // Register the wrap event as a one-clock pulse pair.
    always_ff @(posedge clk) begin
        if (!rst_n) wrap_q <= WRAP_NONE;
        else        wrap_q <= wrap_d;
    end
endmodule

// File: rtl/loop_filter_counter.sv
// Module: top of the programmable-length up/down loop-filter counter.
// Assumes: all inputs are synchronous to clk. span_code may change at any cycle.
module loop_filter_counter
    import lfc_pkg::*;
#(
    parameter int CODE_W  = 4,
    parameter int MIN_EXP = 3,
    parameter int CNT_W   = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic              dir_dn,
    input  logic [CODE_W-1:0] span_code,
    output logic              carry_pulse,
    output logic              borrow_pulse
);
    logic [CNT_W-1:0] mask;
    logic             active;
    logic             step_en;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    wrap_t            wrap_d;
    wrap_t            wrap_q;

    lfc_modulus_decode #(
        .CODE_W (CODE_W),
        .MIN_EXP(MIN_EXP),
        .CNT_W  (CNT_W)
    ) u_decode (
        .span_code(span_code),
        .mask     (mask),
        .active   (active)
    );

    // A step happens only when enabled and the span code is non-zero.
    always_comb step_en = cnt_en && active;

    lfc_step_core #(
        .CNT_W(CNT_W)
    ) u_core (
        .cnt_q  (cnt_q),
        .mask   (mask),
        .step_en(step_en),
        .dir_dn (dir_dn),
        .cnt_d  (cnt_d),
        .wrap_d (wrap_d)
    );

    lfc_state_reg #(
        .CNT_W(CNT_W)
    ) u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_d (cnt_d),
        .wrap_d(wrap_d),
        .cnt_q (cnt_q),
        .wrap_q(wrap_q)
    );

    // Drive the pulse outputs from the registered wrap pair.
    always_comb begin
        carry_pulse  = wrap_q.carry;
        borrow_pulse = wrap_q.borrow;
    end
endmodule

// File: rtl/lfc_checker.sv
// Module: port-level temporal checks for the loop-filter counter, bound to the top.
module lfc_checker #(
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cnt_en,
    input logic              dir_dn,
    input logic [CODE_W-1:0] span_code,
    input logic              carry_pulse,
    input logic              borrow_pulse
);
    // R7
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(carry_pulse && borrow_pulse));

    // R5
    carry_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry_pulse |=> !carry_pulse);

    // R6
    borrow_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        borrow_pulse |=> !borrow_pulse);

    // R2
    inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (span_code == '0) |=> (!carry_pulse && !borrow_pulse));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> (!carry_pulse && !borrow_pulse));

    // R4
    carry_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_dn |=> !borrow_pulse);

    // R4
    borrow_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dir_dn |=> !carry_pulse);
endmodule

bind loop_filter_counter lfc_checker #(.CODE_W(CODE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_en      (cnt_en),
    .dir_dn      (dir_dn),
    .span_code   (span_code),
    .carry_pulse (carry_pulse),
    .borrow_pulse(borrow_pulse)
);

// File: tb/loop_filter_counter_tb.sv
module loop_filter_counter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_en = 1'b0;
    logic       dir_dn = 1'b0;
    logic [3:0] span_code = 4'd0;
    logic       carry_pulse;
    logic       borrow_pulse;

    int n_checks = 0;
    int n_errors = 0;
    int both_high = 0;
    int wide_pulse = 0;
    bit done = 0;

    always #10 clk = ~clk;

    loop_filter_counter u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_en      (cnt_en),
        .dir_dn      (dir_dn),
        .span_code   (span_code),
        .carry_pulse (carry_pulse),
        .borrow_pulse(borrow_pulse)
    );

    // Vector: {req[7:0], code[3:0], pattern[3:0], en[3:0], cycles[15:0], carries[7:0], borrows[7:0]}
    // pattern: 0 up, 1 down, 2 three up then one down, 3 alternate starting up
    localparam int NV = 14;
    localparam logic [51:0] VEC [NV] = '{
        {8'd3,  4'd1,  4'd0, 4'd1, 16'd8,    8'd1, 8'd0},  // R3 K=8 wraps on 8th edge
        {8'd3,  4'd1,  4'd0, 4'd1, 16'd7,    8'd0, 8'd0},  // R3 not before
        {8'd5,  4'd1,  4'd0, 4'd1, 16'd16,   8'd2, 8'd0},  // R5 repeated carries
        {8'd4,  4'd1,  4'd1, 4'd1, 16'd1,    8'd0, 8'd1},  // R4 down from zero borrows
        {8'd6,  4'd1,  4'd1, 4'd1, 16'd9,    8'd0, 8'd2},  // R6 repeated borrows
        {8'd3,  4'd2,  4'd0, 4'd1, 16'd16,   8'd1, 8'd0},  // R3 K=16
        {8'd3,  4'd2,  4'd0, 4'd1, 16'd15,   8'd0, 8'd0},  // R3 K=16 not before
        {8'd2,  4'd0,  4'd0, 4'd1, 16'd100,  8'd0, 8'd0},  // R2 frozen up
        {8'd2,  4'd0,  4'd1, 4'd1, 16'd100,  8'd0, 8'd0},  // R2 frozen down
        {8'd8,  4'd1,  4'd0, 4'd0, 16'd20,   8'd0, 8'd0},  // R8 enable low
        {8'd10, 4'd1,  4'd2, 4'd1, 16'd128,  8'd8, 8'd0},  // R10 net +64 over K=8
        {8'd10, 4'd1,  4'd3, 4'd1, 16'd64,   8'd0, 8'd0},  // R10 net zero
        {8'd3,  4'd10, 4'd0, 4'd1, 16'd4096, 8'd1, 8'd0},  // R3 K=4096
        {8'd11, 4'd15, 4'd1, 4'd1, 16'd1,    8'd0, 8'd1}   // R11 K=131072 borrow
    };

    // Flag overlap and over-wide pulses at each falling edge.
    logic prev_c = 1'b0, prev_b = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (carry_pulse && borrow_pulse) both_high++;
            if ((carry_pulse && prev_c) || (borrow_pulse && prev_b)) wide_pulse++;
        end
        prev_c = carry_pulse;
        prev_b = borrow_pulse;
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cnt_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Run n edges with a direction pattern and return the pulses seen.
    task automatic run(input logic [3:0] code, input int pat, input logic en, input int n,
                       output int nc, output int nb);
        nc = 0;
        nb = 0;
        span_code = code;
        cnt_en = en;
        for (int i = 0; i < n; i++) begin
            case (pat)
                0: dir_dn = 1'b0;
                1: dir_dn = 1'b1;
                2: dir_dn = ((i % 4) == 3);
                default: dir_dn = i[0];
            endcase
            @(posedge clk);
            @(negedge clk);
            if (carry_pulse) nc++;
            if (borrow_pulse) nb++;
        end
    endtask

    initial begin
        int c, b;
        @(negedge clk);
        do_reset();
        // R1: outputs low right after reset
        check("R1 carry after reset", carry_pulse, 0);
        check("R1 borrow after reset", borrow_pulse, 0);

        for (int v = 0; v < NV; v++) begin
            do_reset();
            run(VEC[v][43:40], int'(VEC[v][39:36]), VEC[v][32], int'(VEC[v][31:16]), c, b);
            check($sformatf("R%0d vec%0d carries", VEC[v][51:44], v), c, int'(VEC[v][15:8]));
            check($sformatf("R%0d vec%0d borrows", VEC[v][51:44], v), b, int'(VEC[v][7:0]));
        end

        // R1: reset mid-run restarts from zero
        do_reset();
        run(4'd1, 0, 1'b1, 5, c, b);
        do_reset();
        run(4'd1, 0, 1'b1, 7, c, b);
        check("R1 no carry 7 edges after re-reset", c, 0);
        run(4'd1, 0, 1'b1, 1, c, b);
        check("R1 carry on 8th edge after re-reset", c, 1);

        // R9: count 20 under K=32 folds to 4 under K=8
        do_reset();
        run(4'd3, 0, 1'b1, 20, c, b);
        check("R9 no carry below K=32", c, 0);
        run(4'd1, 0, 1'b1, 3, c, b);
        check("R9 no stray pulse after shrink", c + b, 0);
        run(4'd1, 0, 1'b1, 1, c, b);
        check("R9 carry on 4th edge from folded 4", c, 1);

        // R9: count 13 folds to 5, then down needs 6 edges to borrow
        do_reset();
        run(4'd3, 0, 1'b1, 13, c, b);
        run(4'd1, 1, 1'b1, 5, c, b);
        check("R9 no borrow while folded count falls", b, 0);
        run(4'd1, 1, 1'b1, 1, c, b);
        check("R9 borrow on 6th down edge", b, 1);

        // R2: frozen code keeps the count
        do_reset();
        run(4'd1, 0, 1'b1, 5, c, b);
        run(4'd0, 1, 1'b1, 50, c, b);
        check("R2 no pulse while frozen", c + b, 0);
        run(4'd1, 0, 1'b1, 2, c, b);
        check("R2 count kept 5 -> 7 without carry", c, 0);
        run(4'd1, 0, 1'b1, 1, c, b);
        check("R2 carry after unfreeze", c, 1);

        // R8: enable low keeps the count
        do_reset();
        run(4'd1, 0, 1'b1, 6, c, b);
        run(4'd1, 1, 1'b0, 30, c, b);
        check("R8 no pulse while disabled", c + b, 0);
        run(4'd1, 0, 1'b1, 1, c, b);
        check("R8 count kept 6 -> 7", c, 0);
        run(4'd1, 0, 1'b1, 1, c, b);
        check("R8 carry on next edge", c, 1);

        check("R7 carry and borrow never together", both_high, 0);
        check("R5 R6 pulses one clock wide", wide_pulse, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule